// File: doc/BRIEF.md
# Multi-Mode Interrupt Trigger Controller

This block gathers 32 interrupt lines and turns them into two request outputs for a processor. Each line has its own three-bit trigger code that picks rising-edge, falling-edge, any-edge, active-high level or active-low level detection, or switches the line off. Edges are held in two capture vectors, one for rising and one for falling transitions, until software clears them by writing ones. Each line is steered to request 0 or request 1 and only reaches that request while its enable bit is set. A separate wake-enable vector drives a wake output that ignores the enables.

Software reaches every state vector over a small single-cycle register bus. Each stored vector has a read slot, a set slot and a clear slot, so single bits can be changed without a read-modify-write, and the whole state can be read back for save and restore. A source-select vector and a test vector let software drive any line from a register instead of the pin.

The block has no state machine. All of its state is a set of bit vectors that bus writes and line events update, and each request output is a combinational OR over its pending vector.

Top module: `trig_irq_ctrl`

## Requirements
- R1: The trigger code of source i is {plane2[i], plane1[i], plane0[i]}: 001 rising edge, 010 falling edge, 011 either edge, 101 active-high level, 110 active-low level; 000, 100 and 111 never make the source pending.
- R2: The bus address is {group[3:0], op[1:0]} with op 00 read, 01 set, 10 clear. Groups: 0..2 trigger planes 0..2, 3 enable, 4 wake-enable, 5 route, 6 source-select, 7 rising capture, 8 falling capture, 9 pending for request 0, 10 pending for request 1, 11 test vector. On a set or clear, each data bit at 1 sets or clears that bit, and each data bit at 0 leaves it unchanged.
- R3: A rising (falling) transition on a source whose code arms it sets that bit of the rising (falling) capture vector. The bit stays set until a clear write (op 10 to group 7 or 8) with a 1 in that position. Clearing one capture vector leaves the other untouched.
- R4: A pending source with route bit 1 appears in the request 0 pending vector. With route bit 0, it appears in the request 1 pending vector, never in both.
- R5: A source is pending in a request vector only while its enable bit is 1. Captured edges survive while the enable is 0 and appear once it is set again.
- R6: req0_o and req1_o are high exactly when their pending vectors (groups 9 and 10) are non-zero.
- R7: After reset, the trigger planes, enable, wake-enable, both capture vectors and the test vector are 0, route and source-select are all ones, and req0_o, req1_o and wake_o are low.
- R8: wake_o is high when any source is both pending (before enabling) and wake-enabled, whatever its enable bit.
- R9: With source-select bit i at 1, source i follows its pin. At 0, the pin has no effect and bit i of the test vector (written with op 01 to group 11, whole word) drives the source instead. A zero test vector gives normal idle inputs.
- R10: A pin change reaches a level-mode request output after exactly two rising clock edges, through a two-flop synchronizer.
- R11: In level mode, the pending bit is not latched. It drops two edges after the input leaves its active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 32 | Asynchronous interrupt lines |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 6 | Register address {group, op} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed read slot, combinational |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake indication |

## Verification
The hardest case to reach from the ports is an edge captured while its enable is off and then kept, because the capture vector and the enable are separate pieces of state. The stimulus arms a rising-edge source with its enable cleared and toggles the pin. It then reads the capture slot and the pending slot and sets the enable to show the edge surface late. The same captured edge then drives the wake output with the enable off. Next the source is moved to either-edge mode so that both capture vectors hold a bit at once, and the two are cleared one at a time.

// File: rtl/tic_pkg.sv
package tic_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_RSV  = 2'b11
    } bus_op_e;

    typedef enum logic [3:0] {
        G_TRIG0   = 4'd0,
        G_TRIG1   = 4'd1,
        G_TRIG2   = 4'd2,
        G_ENAB    = 4'd3,
        G_WAKE    = 4'd4,
        G_ROUTE   = 4'd5,
        G_SRCSEL  = 4'd6,
        G_RISECAP = 4'd7,
        G_FALLCAP = 4'd8,
        G_PEND0   = 4'd9,
        G_PEND1   = 4'd10,
        G_TEST    = 4'd11,
        G_RSV12   = 4'd12,
        G_RSV13   = 4'd13,
        G_RSV14   = 4'd14,
        G_RSV15   = 4'd15
    } grp_e;

    localparam int GRP_W  = 4;
    localparam int OP_W   = 2;
    localparam int ADDR_W = GRP_W + OP_W;

    localparam logic [2:0] TM_OFF  = 3'b000;
    localparam logic [2:0] TM_RISE = 3'b001;
    localparam logic [2:0] TM_FALL = 3'b010;
    localparam logic [2:0] TM_BOTH = 3'b011;
    localparam logic [2:0] TM_HIGH = 3'b101;
    localparam logic [2:0] TM_LOW  = 3'b110;

endpackage

// File: rtl/tic_sync_edge.sv
module tic_sync_edge #(
    parameter int NSRC   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pin_i,
    input  logic [NSRC-1:0] force_i,
    input  logic [NSRC-1:0] sel_pin_i,
    output logic [NSRC-1:0] lvl_o,
    output logic [NSRC-1:0] rise_o,
    output logic [NSRC-1:0] fall_o
);

    logic [NSRC-1:0] synced;
    logic [NSRC-1:0] prev_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[i]};
            end
        end
        assign synced[i] = chain_q[STAGES-1];
    end

    assign lvl_o = (sel_pin_i & synced) | (~sel_pin_i & force_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_o;
        end
    end

    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;

    // an event cannot be both a rising and a falling transition
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & fall_o) == '0);  // R3

endmodule

// File: rtl/tic_trig.sv
module tic_trig
    import tic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] plane0_i,
    input  logic [NSRC-1:0] plane1_i,
    input  logic [NSRC-1:0] plane2_i,
    input  logic [NSRC-1:0] enab_i,
    input  logic [NSRC-1:0] route_i,
    input  logic [NSRC-1:0] lvl_i,
    input  logic [NSRC-1:0] rcap_i,
    input  logic [NSRC-1:0] fcap_i,
    output logic [NSRC-1:0] rise_arm_o,
    output logic [NSRC-1:0] fall_arm_o,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] pend0_o,
    output logic [NSRC-1:0] pend1_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_dec
        logic [2:0] code;
        assign code = {plane2_i[i], plane1_i[i], plane0_i[i]};
        always_comb begin
            rise_arm_o[i] = 1'b0;
            fall_arm_o[i] = 1'b0;
            raw_o[i]      = 1'b0;
            case (code)
                TM_RISE: begin
                    rise_arm_o[i] = 1'b1;
                    raw_o[i]      = rcap_i[i];
                end
                TM_FALL: begin
                    fall_arm_o[i] = 1'b1;
                    raw_o[i]      = fcap_i[i];
                end
                TM_BOTH: begin
                    rise_arm_o[i] = 1'b1;
                    fall_arm_o[i] = 1'b1;
                    raw_o[i]      = rcap_i[i] | fcap_i[i];
                end
                TM_HIGH: raw_o[i] = lvl_i[i];
                TM_LOW:  raw_o[i] = ~lvl_i[i];
                default: raw_o[i] = 1'b0;
            endcase
        end
    end

    logic [NSRC-1:0] gated;
    assign gated   = raw_o & enab_i;
    assign pend0_o = gated & route_i;
    assign pend1_o = gated & ~route_i;

    AST_PEND_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend0_o & pend1_o) == '0);  // R4
    AST_PEND_NEEDS_ENAB: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend0_o | pend1_o) & ~enab_i) == '0);  // R5

endmodule

// File: rtl/tic_regs.sv
module tic_regs
    import tic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic [NSRC-1:0]   rise_hit_i,
    input  logic [NSRC-1:0]   fall_hit_i,
    input  logic [NSRC-1:0]   pend0_i,
    input  logic [NSRC-1:0]   pend1_i,
    output logic [NSRC-1:0]   plane0_o,
    output logic [NSRC-1:0]   plane1_o,
    output logic [NSRC-1:0]   plane2_o,
    output logic [NSRC-1:0]   enab_o,
    output logic [NSRC-1:0]   wake_o,
    output logic [NSRC-1:0]   route_o,
    output logic [NSRC-1:0]   srcsel_o,
    output logic [NSRC-1:0]   test_o,
    output logic [NSRC-1:0]   rcap_o,
    output logic [NSRC-1:0]   fcap_o,
    output logic [NSRC-1:0]   rdata_o
);

    grp_e    grp;
    bus_op_e op;
    assign grp = grp_e'(addr_i[ADDR_W-1:OP_W]);
    assign op  = bus_op_e'(addr_i[OP_W-1:0]);

    logic set_w, clr_w;
    assign set_w = we_i && (op == OP_SET);
    assign clr_w = we_i && (op == OP_CLR);

    function automatic logic [NSRC-1:0] upd(input logic [NSRC-1:0] cur,
                                            input logic s, input logic c,
                                            input logic [NSRC-1:0] d);
        if (s)      return cur | d;
        else if (c) return cur & ~d;
        else        return cur;
    endfunction

    logic rclr, fclr;
    assign rclr = clr_w && (grp == G_RISECAP);
    assign fclr = clr_w && (grp == G_FALLCAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane0_o <= '0;
            plane1_o <= '0;
            plane2_o <= '0;
            enab_o   <= '0;
            wake_o   <= '0;
            route_o  <= '1;
            srcsel_o <= '1;
            test_o   <= '0;
            rcap_o   <= '0;
            fcap_o   <= '0;
        end else begin
            plane0_o <= upd(plane0_o, set_w && grp == G_TRIG0,  clr_w && grp == G_TRIG0,  wdata_i);
            plane1_o <= upd(plane1_o, set_w && grp == G_TRIG1,  clr_w && grp == G_TRIG1,  wdata_i);
            plane2_o <= upd(plane2_o, set_w && grp == G_TRIG2,  clr_w && grp == G_TRIG2,  wdata_i);
            enab_o   <= upd(enab_o,   set_w && grp == G_ENAB,   clr_w && grp == G_ENAB,   wdata_i);
            wake_o   <= upd(wake_o,   set_w && grp == G_WAKE,   clr_w && grp == G_WAKE,   wdata_i);
            route_o  <= upd(route_o,  set_w && grp == G_ROUTE,  clr_w && grp == G_ROUTE,  wdata_i);
            srcsel_o <= upd(srcsel_o, set_w && grp == G_SRCSEL, clr_w && grp == G_SRCSEL, wdata_i);
            if (set_w && grp == G_TEST) begin
                test_o <= wdata_i;
            end
            // new events win over a clear landing in the same cycle
            rcap_o <= (rcap_o & ~(rclr ? wdata_i : '0)) | rise_hit_i;
            fcap_o <= (fcap_o & ~(fclr ? wdata_i : '0)) | fall_hit_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (op == OP_READ) begin
            case (grp)
                G_TRIG0:   rdata_o = plane0_o;
                G_TRIG1:   rdata_o = plane1_o;
                G_TRIG2:   rdata_o = plane2_o;
                G_ENAB:    rdata_o = enab_o;
                G_WAKE:    rdata_o = wake_o;
                G_ROUTE:   rdata_o = route_o;
                G_SRCSEL:  rdata_o = srcsel_o;
                G_RISECAP: rdata_o = rcap_o;
                G_FALLCAP: rdata_o = fcap_o;
                G_PEND0:   rdata_o = pend0_i;
                G_PEND1:   rdata_o = pend1_i;
                G_TEST:    rdata_o = test_o;
                default:   rdata_o = '0;
            endcase
        end
    end

    AST_PLANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(plane0_o) && $stable(enab_o) && $stable(route_o)));  // R2
    AST_RCAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rclr |=> ((rcap_o & $past(rcap_o)) == $past(rcap_o)));  // R3
    AST_FCAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !fclr |=> ((fcap_o & $past(fcap_o)) == $past(fcap_o)));  // R3

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
    import tic_pkg::*;
#(
    parameter int NSRC        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_pin_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NSRC-1:0]   bus_wdata_i,
    output logic [NSRC-1:0]   bus_rdata_o,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);

    logic [NSRC-1:0] plane0, plane1, plane2, enab, wake_en, route, srcsel, testv;
    logic [NSRC-1:0] rcap, fcap, lvl, rise_ev, fall_ev;
    logic [NSRC-1:0] rise_arm, fall_arm, raw, pend0, pend1;

    tic_sync_edge #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (irq_pin_i),
        .force_i  (testv),
        .sel_pin_i(srcsel),
        .lvl_o    (lvl),
        .rise_o   (rise_ev),
        .fall_o   (fall_ev)
    );

    tic_trig #(.NSRC(NSRC)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .plane0_i  (plane0),
        .plane1_i  (plane1),
        .plane2_i  (plane2),
        .enab_i    (enab),
        .route_i   (route),
        .lvl_i     (lvl),
        .rcap_i    (rcap),
        .fcap_i    (fcap),
        .rise_arm_o(rise_arm),
        .fall_arm_o(fall_arm),
        .raw_o     (raw),
        .pend0_o   (pend0),
        .pend1_o   (pend1)
    );

    tic_regs #(.NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .rise_hit_i(rise_ev & rise_arm),
        .fall_hit_i(fall_ev & fall_arm),
        .pend0_i   (pend0),
        .pend1_i   (pend1),
        .plane0_o  (plane0),
        .plane1_o  (plane1),
        .plane2_o  (plane2),
        .enab_o    (enab),
        .wake_o    (wake_en),
        .route_o   (route),
        .srcsel_o  (srcsel),
        .test_o    (testv),
        .rcap_o    (rcap),
        .fcap_o    (fcap),
        .rdata_o   (bus_rdata_o)
    );

    assign req0_o = |pend0;
    assign req1_o = |pend1;
    assign wake_o = |(raw & wake_en);

    AST_REQ0_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        req0_o |-> ((enab & route) != '0));  // R4
    AST_REQ1_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        req1_o |-> ((enab & ~route) != '0));  // R4
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (wake_en != '0));  // R8

endmodule

// File: tb/sim_trig_irq_ctrl.sv
module sim_trig_irq_ctrl;
    import tic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req0, req1, wake;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    trig_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(pin), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .req0_o(req0), .req1_o(req1), .wake_o(wake)
    );

    // {src[4:0], code[2:0], route, stim(1 = pulse high then low), hit}
    localparam int NV = 13;
    localparam logic [10:0] TBL [NV] = '{
        {5'd3,  3'b001, 1'b1, 1'b1, 1'b1},
        {5'd7,  3'b001, 1'b0, 1'b0, 1'b1},
        {5'd12, 3'b010, 1'b1, 1'b0, 1'b0},
        {5'd13, 3'b010, 1'b0, 1'b1, 1'b1},
        {5'd20, 3'b011, 1'b1, 1'b0, 1'b1},
        {5'd21, 3'b011, 1'b0, 1'b1, 1'b1},
        {5'd31, 3'b101, 1'b1, 1'b0, 1'b1},
        {5'd30, 3'b101, 1'b0, 1'b1, 1'b0},
        {5'd5,  3'b110, 1'b1, 1'b0, 1'b0},
        {5'd6,  3'b110, 1'b0, 1'b1, 1'b1},
        {5'd9,  3'b000, 1'b1, 1'b1, 1'b0},
        {5'd10, 3'b100, 1'b1, 1'b0, 1'b0},
        {5'd11, 3'b111, 1'b0, 1'b1, 1'b0}
    };

    function automatic logic [5:0] ad(input grp_e g, input bus_op_e o);
        return {g, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input grp_e g, input bus_op_e o, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = ad(g, o); wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input grp_e g, output logic [31:0] d);
        @(negedge clk);
        addr = ad(g, OP_READ);
        #1 d = rdata;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        pin = v;
    endtask

    task automatic clean();
        wr(G_TRIG0, OP_CLR, '1);
        wr(G_TRIG1, OP_CLR, '1);
        wr(G_TRIG2, OP_CLR, '1);
        wr(G_ENAB,  OP_CLR, '1);
        wr(G_WAKE,  OP_CLR, '1);
        wr(G_ROUTE, OP_SET, '1);
        wr(G_SRCSEL, OP_SET, '1);
        wr(G_TEST,  OP_SET, '0);
        drive('0);
        cyc(4);
        wr(G_RISECAP, OP_CLR, '1);
        wr(G_FALLCAP, OP_CLR, '1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R7 reset state
        chk("R7 req0", {31'd0, req0}, 32'd0);
        chk("R7 req1", {31'd0, req1}, 32'd0);
        chk("R7 wake", {31'd0, wake}, 32'd0);
        rd(G_TRIG0, v);  chk("R7 plane0", v, 32'h0);
        rd(G_ENAB, v);   chk("R7 enable", v, 32'h0);
        rd(G_ROUTE, v);  chk("R7 route", v, 32'hFFFF_FFFF);
        rd(G_SRCSEL, v); chk("R7 srcsel", v, 32'hFFFF_FFFF);
        rd(G_TEST, v);   chk("R7 test", v, 32'h0);
        rd(G_RISECAP, v); chk("R7 rise capture", v, 32'h0);

        // R2 set / clear semantics
        wr(G_ENAB, OP_SET, 32'h0000_00F0);
        wr(G_ENAB, OP_SET, 32'h0000_000F);
        rd(G_ENAB, v); chk("R2 set merges", v, 32'h0000_00FF);
        wr(G_ENAB, OP_CLR, 32'h0000_0030);
        rd(G_ENAB, v); chk("R2 clear bits", v, 32'h0000_00CF);
        wr(G_ENAB, OP_CLR, 32'h0);
        rd(G_ENAB, v); chk("R2 zero clear unchanged", v, 32'h0000_00CF);
        wr(G_TRIG2, OP_SET, 32'h8000_0001);
        rd(G_TRIG2, v); chk("R2 plane2 readback", v, 32'h8000_0001);
        clean();

        // R1 / R4 / R6 vector table
        for (int k = 0; k < NV; k++) begin
            logic [4:0]  s;
            logic [2:0]  code;
            logic        rt, stim, hit;
            logic [31:0] bit_s, e0, e1;
            {s, code, rt, stim, hit} = TBL[k];
            bit_s = 32'd1 << s;
            if (code[0]) wr(G_TRIG0, OP_SET, bit_s);
            if (code[1]) wr(G_TRIG1, OP_SET, bit_s);
            if (code[2]) wr(G_TRIG2, OP_SET, bit_s);
            if (!rt) wr(G_ROUTE, OP_CLR, bit_s);
            wr(G_ENAB, OP_SET, bit_s);
            cyc(4);
            drive(bit_s);
            cyc(4);
            if (stim) begin
                drive('0);
                cyc(4);
            end
            e0 = (hit && rt)  ? bit_s : 32'h0;
            e1 = (hit && !rt) ? bit_s : 32'h0;
            rd(G_PEND0, v); chk($sformatf("R1 R4 case %0d pend0", k), v, e0);
            rd(G_PEND1, v); chk($sformatf("R1 R4 case %0d pend1", k), v, e1);
            chk($sformatf("R6 case %0d req0", k), {31'd0, req0}, {31'd0, |e0});
            chk($sformatf("R6 case %0d req1", k), {31'd0, req1}, {31'd0, |e1});
            clean();
        end

        // R5: edge captured while disabled is kept
        wr(G_TRIG0, OP_SET, 32'h10);
        drive(32'h10);
        cyc(4);
        rd(G_PEND0, v); chk("R5 masked not pending", v, 32'h0);
        chk("R5 masked req0 low", {31'd0, req0}, 32'd0);
        rd(G_RISECAP, v); chk("R3 rise captured", v, 32'h10);
        wr(G_ENAB, OP_SET, 32'h10);
        rd(G_PEND0, v); chk("R5 kept edge appears", v, 32'h10);
        chk("R5 req0 high", {31'd0, req0}, 32'd1);

        // R8: wake ignores enable
        wr(G_ENAB, OP_CLR, 32'h10);
        wr(G_WAKE, OP_SET, 32'h10);
        chk("R8 wake with enable off", {31'd0, wake}, 32'd1);
        chk("R8 req0 stays low", {31'd0, req0}, 32'd0);
        wr(G_WAKE, OP_CLR, 32'h10);
        chk("R8 wake off", {31'd0, wake}, 32'd0);

        // R3: both captures, cleared separately
        wr(G_TRIG1, OP_SET, 32'h10);
        drive('0);
        cyc(4);
        wr(G_ENAB, OP_SET, 32'h10);
        wr(G_RISECAP, OP_CLR, 32'h10);
        rd(G_RISECAP, v); chk("R3 rise cleared", v, 32'h0);
        rd(G_FALLCAP, v); chk("R3 fall kept", v, 32'h10);
        rd(G_PEND0, v); chk("R3 fall still pends", v, 32'h10);
        wr(G_FALLCAP, OP_CLR, 32'h10);
        rd(G_PEND0, v); chk("R3 all cleared", v, 32'h0);
        clean();

        // R9: test vector drives a deselected source
        wr(G_TRIG0, OP_SET, 32'h100);
        wr(G_TRIG2, OP_SET, 32'h100);
        wr(G_ENAB, OP_SET, 32'h100);
        wr(G_SRCSEL, OP_CLR, 32'h100);
        drive(32'h100);
        cyc(4);
        rd(G_PEND0, v); chk("R9 pin ignored", v, 32'h0);
        wr(G_TEST, OP_SET, 32'h100);
        rd(G_PEND0, v); chk("R9 test drives", v, 32'h100);
        wr(G_TEST, OP_SET, 32'h0);
        rd(G_PEND0, v); chk("R9 test zero idle", v, 32'h0);
        wr(G_SRCSEL, OP_SET, 32'h100);
        rd(G_PEND0, v); chk("R9 pin reselected", v, 32'h100);
        clean();

        // R10 / R11: synchronizer latency and unlatched level
        wr(G_TRIG0, OP_SET, 32'h4);
        wr(G_TRIG2, OP_SET, 32'h4);
        wr(G_ROUTE, OP_CLR, 32'h4);
        wr(G_ENAB, OP_SET, 32'h4);
        drive(32'h4);
        cyc(1);
        chk("R10 one edge not yet", {31'd0, req1}, 32'd0);
        cyc(1);
        chk("R10 two edges visible", {31'd0, req1}, 32'd1);
        drive('0);
        cyc(1);
        chk("R11 level still held", {31'd0, req1}, 32'd1);
        cyc(1);
        chk("R11 level dropped", {31'd0, req1}, 32'd0);
        clean();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule